// File: doc/BRIEF.md
# Sampling Converter Control Interface

This block is the digital control side of a 16-bit sampling converter, written as a clocked, synthesizable model. A host drives an active-low select, a combined convert/read line and a lane-swap input. The block runs an acquire phase and a convert phase with cycle counters and reports progress on a ready line that is low while a conversion runs. The converted value is not computed. It is taken from an injected sample input at the start of the conversion and moved into the result register at the end.

The output bus is enabled only for a read. During a conversion, the previous result stays visible for a short window and is then replaced by zeros until the new result lands. Holding both control lines low across the end of a conversion starts the next one without acquisition, and that result carries an invalid flag. While a conversion runs, a qualified low pulse on convert/read abandons it and increments an abort counter.

Top module: `convIfTop`

## Requirements
- R1: While `rstN` is low, `ready` is 1, `outEn` is 0, and `outBus`, `result`, `invalidRes` and `abortCnt` are all zero. The acquisition counter restarts from zero at reset.
- R2: When idle, a conversion starts on the first clock edge at which both `selectN` and `convRead` are sampled low. `ready` then reads 0 for exactly CONV_CYC cycles. With only one of the two lines low, no conversion starts.
- R3: `sampleIn` is captured on the start edge and written to `result` on the edge where `ready` returns to 1. Later changes to `sampleIn` have no effect on that result, and `result` changes at no other time.
- R4: `outEn` is 1 only when `selectN` is 0 and `convRead` is 1. At every other time, `outBus` is all zeros.
- R5: With `laneSwap` = 0, `outBus` carries the data word unchanged. With `laneSwap` = 1, bits 7..0 appear on `outBus[15:8]` and bits 15..8 appear on `outBus[7:0]`.
- R6: While a conversion is in progress and the bus is enabled, the previous result is shown during the first VALID_WIN cycles of `ready` low. After that, the bus shows zero until `ready` rises.
- R7: If `selectN` and `convRead` are still both low when `ready` rises, a new conversion starts on the next edge. When that conversion completes, `invalidRes` is 1. A conversion started after at least ACQ_CYC idle cycles completes with `invalidRes` = 0.
- R8: During a conversion, a stretch of `convRead` low that follows a high level aborts the conversion once the low level has been sampled on MIN_PULSE consecutive edges. After an abort, `ready` is 1, `result` and `invalidRes` are unchanged, and `abortCnt` is one higher. A shorter low stretch has no effect.
- R9: After an abort, no conversion starts until `selectN` or `convRead` has been seen high.
- R10: If an abort would qualify on the same edge on which the conversion completes, the completion takes effect and the abort is dropped: `result` updates and `abortCnt` stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selectN | input | 1 | Chip select, active low |
| convRead | input | 1 | Low requests a conversion, high requests a read |
| laneSwap | input | 1 | Swaps the two byte lanes of the output bus |
| sampleIn | input | 16 | Injected value that stands in for the conversion result |
| ready | output | 1 | Low while a conversion is in progress |
| outEn | output | 1 | Output bus enable |
| outBus | output | 16 | Byte-laned read data, zero when not enabled |
| result | output | 16 | Most recent completed result |
| invalidRes | output | 1 | The current result was converted without acquisition |
| abortCnt | output | 8 | Number of aborted conversions, saturating |

## Verification
Completion and abort can fall on the same edge: the last cycle of a conversion can also be the edge on which a convert/read low stretch reaches its qualifying length. The bench starts the low stretch at a chosen offset so that it qualifies on exactly the completion edge, and in a second run one edge earlier. The outcome is judged at the ports. In the first run, `result` must take the new sample with `abortCnt` unchanged. In the second run, `ready` must rise one cycle early with `result` unchanged and `abortCnt` incremented.

// File: rtl/convIfPkg.sv
package convIfPkg;
  typedef enum logic {PH_ACQ = 1'b0, PH_CONV = 1'b1} phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture; // sample the input and start
    logic unacq;   // started without full acquisition
    logic commit;  // conversion finished, move held value to result
    logic abort;   // conversion abandoned
    logic dataOk;  // bus may show the stored result
  } strobe_t;
endpackage

// File: rtl/convIfCtrl.sv
module convIfCtrl
  import convIfPkg::*;
#(
  parameter int CONV_CYC  = 16,
  parameter int ACQ_CYC   = 8,
  parameter int MIN_PULSE = 4,
  parameter int VALID_WIN = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    selectN,
  input  logic    convRead,
  output logic    ready,
  output logic    outEn,
  output strobe_t strb
);
  localparam int CW = $clog2(CONV_CYC + 1);
  localparam int AW = $clog2(ACQ_CYC + 1);
  localparam int PW = $clog2(MIN_PULSE + 1);

  phase_e        phase;
  logic [CW-1:0] convCnt;
  logic [AW-1:0] acqCnt;
  logic [PW-1:0] lowCnt;
  logic          armed;
  logic          needRelease;
  logic          trig, startNow, done, abortNow;

  always_comb begin
    trig     = !selectN && !convRead;
    startNow = (phase == PH_ACQ) && trig && !needRelease;
    done     = (phase == PH_CONV) && (convCnt == CW'(CONV_CYC - 1));
    abortNow = (phase == PH_CONV) && armed && !convRead &&
               (lowCnt == PW'(MIN_PULSE - 1)) && !done;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_ACQ;
      convCnt     <= '0;
      acqCnt      <= '0;
      lowCnt      <= '0;
      armed       <= 1'b0;
      needRelease <= 1'b0;
    end else begin
      case (phase)
        PH_ACQ: begin
          if (!trig) needRelease <= 1'b0;
          if (acqCnt != AW'(ACQ_CYC)) acqCnt <= acqCnt + AW'(1);
          if (startNow) begin
            phase   <= PH_CONV;
            convCnt <= '0;
            armed   <= 1'b0;
            lowCnt  <= '0;
          end
        end
        default: begin
          if (done) begin
            phase  <= PH_ACQ;
            acqCnt <= '0;
          end else if (abortNow) begin
            phase       <= PH_ACQ;
            acqCnt      <= '0;
            needRelease <= 1'b1;
          end else begin
            convCnt <= convCnt + CW'(1);
            armed   <= armed | convRead;
            lowCnt  <= (armed && !convRead) ? lowCnt + PW'(1) : '0;
          end
        end
      endcase
    end
  end

  always_comb begin
    ready       = (phase == PH_ACQ);
    outEn       = !selectN && convRead;
    strb.capture = startNow;
    strb.unacq   = (acqCnt < AW'(ACQ_CYC));
    strb.commit  = done;
    strb.abort   = abortNow;
    strb.dataOk  = (phase == PH_ACQ) || (int'(convCnt) < VALID_WIN);
  end

  // R2
  minConv_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |=> !ready);

  // R8
  abortIdle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> ready);

  // R9
  holdOff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.abort && !selectN && !convRead) |=> ready);
endmodule

// File: rtl/convIfData.sv
module convIfData
  import convIfPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              outEn,
  input  logic              laneSwap,
  output logic [DATA_W-1:0] outBus,
  output logic [DATA_W-1:0] result,
  output logic              invalidRes,
  output logic [CNT_W-1:0]  abortCnt
);
  localparam int LANE_W = DATA_W / 2;

  logic [DATA_W-1:0] held;
  logic              pendInv;
  logic [DATA_W-1:0] word;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held       <= '0;
      pendInv    <= 1'b0;
      result     <= '0;
      invalidRes <= 1'b0;
      abortCnt   <= '0;
    end else begin
      if (strb.capture) begin
        held    <= sampleIn;
        pendInv <= strb.unacq;
      end
      if (strb.commit) begin
        result     <= held;
        invalidRes <= pendInv;
      end
      if (strb.abort && (abortCnt != {CNT_W{1'b1}}))
        abortCnt <= abortCnt + CNT_W'(1);
    end
  end

  assign word = strb.dataOk ? result : '0;

  for (genvar g = 0; g < 2; g++) begin : gLane
    always_comb begin
      if (!outEn)
        outBus[g*LANE_W +: LANE_W] = '0;
      else if (laneSwap)
        outBus[g*LANE_W +: LANE_W] = word[(1-g)*LANE_W +: LANE_W];
      else
        outBus[g*LANE_W +: LANE_W] = word[g*LANE_W +: LANE_W];
    end
  end

  // R3
  resultHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(result));

  // R7
  invHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(invalidRes));
endmodule

// File: rtl/convIfTop.sv
module convIfTop
  import convIfPkg::*;
#(
  parameter int CONV_CYC  = 16,
  parameter int ACQ_CYC   = 8,
  parameter int MIN_PULSE = 4,
  parameter int VALID_WIN = 5,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selectN,
  input  logic              convRead,
  input  logic              laneSwap,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              ready,
  output logic              outEn,
  output logic [DATA_W-1:0] outBus,
  output logic [DATA_W-1:0] result,
  output logic              invalidRes,
  output logic [CNT_W-1:0]  abortCnt
);
  strobe_t strb;

  convIfCtrl #(
    .CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC),
    .MIN_PULSE(MIN_PULSE), .VALID_WIN(VALID_WIN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .selectN(selectN), .convRead(convRead),
    .ready(ready), .outEn(outEn), .strb(strb)
  );

  convIfData #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleIn(sampleIn),
    .outEn(outEn), .laneSwap(laneSwap), .outBus(outBus),
    .result(result), .invalidRes(invalidRes), .abortCnt(abortCnt)
  );

  // R4
  busQuiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> (outBus == '0));

  // R8
  abortOnlyBusy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortCnt != $past(abortCnt)) |-> $rose(ready));

  // R3
  resultAtEnd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (result != $past(result)) |-> $rose(ready));
endmodule

// File: tb/convIfTop_bench.sv
`timescale 1ns/1ps
module convIfTop_bench;
  localparam int CONV  = 16;
  localparam int ACQ   = 8;
  localparam int PULSE = 4;
  localparam int WIN   = 5;

  logic        clk = 1'b0;
  logic        rstN, selectN, convRead, laneSwap;
  logic [15:0] sampleIn;
  logic        ready, outEn, invalidRes;
  logic [15:0] outBus, result;
  logic [7:0]  abortCnt;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  convIfTop #(.CONV_CYC(CONV), .ACQ_CYC(ACQ), .MIN_PULSE(PULSE), .VALID_WIN(WIN))
  u_convIfTop (
    .clk(clk), .rstN(rstN), .selectN(selectN), .convRead(convRead),
    .laneSwap(laneSwap), .sampleIn(sampleIn), .ready(ready), .outEn(outEn),
    .outBus(outBus), .result(result), .invalidRes(invalidRes), .abortCnt(abortCnt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lanes(input logic [15:0] w, input logic sw);
    return sw ? {w[7:0], w[15:8]} : w;
  endfunction

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // normal acquired conversion, then read with both lane orders
  task automatic convertNormal(input logic [15:0] val, input logic [15:0] prev);
    sampleIn = val; selectN = 1'b0; convRead = 1'b0;
    tick();
    chk("R2 ready low at start", ready, 0);
    sampleIn = ~val; convRead = 1'b1;
    for (int i = 2; i <= CONV; i++) begin
      tick();
      chk("R2 ready low during conversion", ready, 0);
      chk("R6 bus during conversion", outBus,
          (i <= WIN) ? lanes(prev, laneSwap) : 16'h0000);
    end
    tick();
    chk("R2 ready high after conversion", ready, 1);
    chk("R3 result captured", result, val);
    chk("R5 lane order", outBus, lanes(val, laneSwap));
    chk("R7 acquired result valid", invalidRes, 0);
    laneSwap = ~laneSwap; #1;
    chk("R5 lane order swapped", outBus, lanes(val, laneSwap));
    laneSwap = ~laneSwap;
    selectN = 1'b1;
    tick(ACQ + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] prev, val, a, b;
    logic [7:0]  ab;
    rstN = 1'b0; selectN = 1'b1; convRead = 1'b1; laneSwap = 1'b0; sampleIn = 16'h0;
    tick(3);
    chk("R1 reset ready", ready, 1);
    chk("R1 reset outEn", outEn, 0);
    chk("R1 reset bus", outBus, 0);
    chk("R1 reset result", result, 0);
    chk("R1 reset invalid", invalidRes, 0);
    chk("R1 reset abortCnt", abortCnt, 0);
    rstN = 1'b1;
    tick(ACQ + 2);

    // sweep of values, corners first
    prev = 16'h0000;
    for (int k = 0; k < 12; k++) begin
      case (k)
        0: val = 16'h7FFF;
        1: val = 16'h8000;
        2: val = 16'hFFFF;
        3: val = 16'h0000;
        default: val = 16'(k * 16'h3A5B + 7);
      endcase
      laneSwap = k[0];
      convertNormal(val, prev);
      prev = val;
    end
    laneSwap = 1'b0;

    // R7 back-to-back without acquisition
    a = 16'h1357; b = 16'hC0DE;
    sampleIn = a; selectN = 1'b0; convRead = 1'b0;
    tick();
    sampleIn = b;
    tick(CONV - 1);
    chk("R7 first still busy", ready, 0);
    tick();
    chk("R7 first done", ready, 1);
    chk("R7 first result", result, a);
    chk("R7 first valid", invalidRes, 0);
    tick();
    chk("R7 immediate restart", ready, 0);
    selectN = 1'b1; sampleIn = ~b;
    tick(CONV - 1);
    chk("R7 second busy", ready, 0);
    tick();
    chk("R7 second done", ready, 1);
    chk("R7 second result", result, b);
    chk("R7 unacquired flagged", invalidRes, 1);
    chk("R7 no abort counted", abortCnt, 0);
    tick(ACQ + 1);
    convertNormal(16'h2468, b);
    prev = 16'h2468;

    // R8 abort with short and qualifying pulses
    ab = abortCnt;
    sampleIn = 16'hAAAA; selectN = 1'b0; convRead = 1'b0;
    tick();
    convRead = 1'b1;
    tick(3);
    convRead = 1'b0;
    tick(3);
    chk("R8 short pulse ignored ready", ready, 0);
    chk("R8 short pulse ignored count", abortCnt, ab);
    convRead = 1'b1;
    tick();
    convRead = 1'b0;
    tick(3);
    chk("R8 not yet aborted", ready, 0);
    tick();
    chk("R8 aborted ready", ready, 1);
    chk("R8 abort count", abortCnt, ab + 8'd1);
    chk("R8 result kept", result, prev);
    chk("R8 invalid kept", invalidRes, 0);
    tick(3);
    chk("R9 no restart while held low", ready, 1);
    convRead = 1'b1;
    tick(ACQ + 1);
    sampleIn = 16'h5A5A; convRead = 1'b0;
    tick();
    chk("R9 restart after release", ready, 0);
    convRead = 1'b1;
    tick(CONV);
    chk("R9 restarted result", result, 16'h5A5A);
    chk("R9 restarted valid", invalidRes, 0);
    prev = 16'h5A5A;
    selectN = 1'b1;
    tick(ACQ + 1);

    // R10 abort qualifying one edge before completion: abort wins
    ab = abortCnt;
    sampleIn = 16'h0F0F; selectN = 1'b0; convRead = 1'b0;
    tick();
    convRead = 1'b1;
    tick(11);
    convRead = 1'b0; selectN = 1'b1;
    tick(3);
    chk("R10 early abort pending", ready, 0);
    tick();
    chk("R10 early abort ready", ready, 1);
    chk("R10 early abort count", abortCnt, ab + 8'd1);
    chk("R10 early abort result kept", result, prev);
    convRead = 1'b1;
    tick(ACQ + 1);

    // R10 abort qualifying on the completion edge: completion wins
    ab = abortCnt;
    sampleIn = 16'hF00D; selectN = 1'b0; convRead = 1'b0;
    tick();
    convRead = 1'b1;
    tick(12);
    convRead = 1'b0; selectN = 1'b1;
    tick(3);
    chk("R10 still busy before end", ready, 0);
    tick();
    chk("R10 completion ready", ready, 1);
    chk("R10 completion result", result, 16'hF00D);
    chk("R10 abort dropped", abortCnt, ab);
    convRead = 1'b1;
    tick(ACQ + 1);

    // R4 decode of the enable
    selectN = 1'b1; convRead = 1'b1; #1;
    chk("R4 deselected outEn", outEn, 0);
    chk("R4 deselected bus", outBus, 0);
    convRead = 1'b0; #1;
    chk("R4 convert-only outEn", outEn, 0);
    chk("R4 convert-only bus", outBus, 0);
    tick();
    chk("R2 one line low no start", ready, 1);
    selectN = 1'b0; convRead = 1'b1; #1;
    chk("R4 read outEn", outEn, 1);
    chk("R4 read bus", outBus, 16'hF00D);
    selectN = 1'b1;
    tick(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule